// File: doc/BRIEF.md
# Transpose Request Decoder and Validator

This block sits between an accelerator request port and a copy engine. Each request carries a source, a destination, a length, a tag, a flag that marks the register form of the copy instruction, and a 32-bit configuration operand. Some bits of that operand that a plain copy does not use carry a packed transpose descriptor: an enable, an element mode and two tensor dimensions. The block unpacks that descriptor into a typed option record, checks it, and then does one of two things. It forwards the copy with the record attached, or it retires the request with a coded error response and sends nothing downstream.

Both results come from registered one-entry slots, so the outputs never depend combinationally on the request inputs. The request port is ready whenever each slot is empty or is being drained in the same cycle. The `XPOSE_EN` parameter removes the field checks and the option datapath at elaboration. A request that still asks for a transpose is then refused with a "no hardware" cause. Every other request passes as a plain copy.

Top module: `xpose_req_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `rsp_valid` are low.
- R2: The operand is decoded with the enable in bit 5, the mode in bits 7:6, dimension M in bits 19:8 and dimension N in bits 31:20. A legal transpose is issued with `out_xpose`=1 and these fields on `out_mode`, `out_dim_m` and `out_dim_n`. Tag, addresses, length and operand are forwarded unchanged.
- R3: A register-form request with operand bit 5 clear is issued with `out_xpose`, `out_mode`, `out_dim_m` and `out_dim_n` all zero, and with its payload unchanged, whatever the other operand bits hold.
- R4: A request that is not the register form (`in_regform`=0) is issued as a plain copy with zero options, and is never rejected.
- R5: Mode 00 is 8-bit, 01 is 16-bit and 10 is 32-bit. A transpose with mode 11 is rejected with `rsp_code`=2.
- R6: A transpose with M or N equal to zero is rejected with `rsp_code`=3.
- R7: A transpose whose destination is not a multiple of `BUS_BYTES` is rejected with `rsp_code`=4.
- R8: When several causes apply, the lowest code wins, in this order: 1 (no hardware), then 2 (mode), then 3 (dimension), then 4 (alignment).
- R9: With `XPOSE_EN`=0, a register-form request with bit 5 set is rejected with `rsp_code`=1. Every other request is issued as a plain copy with zero options.
- R10: A rejected request raises `rsp_valid` exactly once, with its tag on `rsp_id`, and issues nothing downstream. The following request is handled as if the rejected one had never arrived.
- R11: While `out_valid` or `rsp_valid` is high and its ready input is low, that output and its payload hold. `in_ready` stays low until the blocked slot drains.
- R12: A request accepted at a clock edge shows its result on `out_valid` or `rsp_valid` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_regform | input | 1 | Request is the register form of the copy instruction |
| in_id | input | ID_W | Request tag |
| in_src | input | ADDR_W | Source address |
| in_dst | input | ADDR_W | Destination address |
| in_len | input | LEN_W | Transfer length in bytes |
| in_cfg | input | 32 | Configuration operand |
| out_valid | output | 1 | Issued copy valid |
| out_ready | input | 1 | Downstream accepts the issued copy |
| out_id | output | ID_W | Issued tag |
| out_src | output | ADDR_W | Issued source address |
| out_dst | output | ADDR_W | Issued destination address |
| out_len | output | LEN_W | Issued length |
| out_cfg | output | 32 | Operand, forwarded unchanged |
| out_xpose | output | 1 | Transpose enabled in the option record |
| out_mode | output | 2 | Element mode of the option record |
| out_dim_m | output | 12 | Dimension M of the option record |
| out_dim_n | output | 12 | Dimension N of the option record |
| rsp_valid | output | 1 | Error response valid |
| rsp_ready | input | 1 | Error response accepted |
| rsp_id | output | ID_W | Tag of the rejected request |
| rsp_code | output | 3 | Rejection cause: 1 no hardware, 2 mode, 3 dimension, 4 alignment |

## Verification
An accepted request has exactly one result, on either `out_valid` or `rsp_valid`. That result is due one cycle after the accepting edge, and it stays there until its ready input is sampled high. `in_ready` follows the slot state and the two ready inputs within the same cycle. The bench drives inputs 1 ns after each rising edge. A behavioural model advances on the rising edge from those inputs alone, and every falling edge compares the model with both DUT copies, the one built with transpose support and the one built without it. Directed requests cover each rejection cause, the priority among them and the no-hardware build. A pseudo-random phase with random ready inputs exercises holding under back-pressure and back-to-back acceptance.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

  localparam int unsigned CFG_W      = 32;
  localparam int unsigned DIM_W      = 12;
  localparam int unsigned EN_BIT     = 5;
  localparam int unsigned MODE_LO    = 6;
  localparam int unsigned DIM_M_LO   = 8;
  localparam int unsigned DIM_N_LO   = 20;

  typedef enum logic [1:0] {
    ELEM_8  = 2'b00,
    ELEM_16 = 2'b01,
    ELEM_32 = 2'b10,
    ELEM_RSVD = 2'b11
  } elem_mode_e;

  typedef enum logic [2:0] {
    REJ_NONE  = 3'd0,
    REJ_NO_HW = 3'd1,
    REJ_MODE  = 3'd2,
    REJ_DIM   = 3'd3,
    REJ_ALIGN = 3'd4
  } rej_code_e;

  typedef struct packed {
    logic             en;
    elem_mode_e       mode;
    logic [DIM_W-1:0] dim_m;
    logic [DIM_W-1:0] dim_n;
  } xpose_opt_t;

endpackage

// File: rtl/xpose_field_decode.sv
module xpose_field_decode
  import xpose_pkg::*;
(
  input  logic             regform,
  input  logic [CFG_W-1:0] cfg,
  output xpose_opt_t       raw
);

  always_comb begin
    raw.en    = regform & cfg[EN_BIT];
    raw.mode  = elem_mode_e'(cfg[MODE_LO +: 2]);
    raw.dim_m = cfg[DIM_M_LO +: DIM_W];
    raw.dim_n = cfg[DIM_N_LO +: DIM_W];
  end

endmodule

// File: rtl/xpose_rule_check.sv
module xpose_rule_check
  import xpose_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BUS_BYTES = 8,
  parameter bit          XPOSE_EN  = 1'b1
) (
  input  xpose_opt_t        raw,
  input  logic [ADDR_W-1:0] dst,
  output rej_code_e         code,
  output xpose_opt_t        clean
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BUS_BYTES - 1);

  generate
    if (XPOSE_EN) begin : g_checks
      logic bad_mode, bad_dim, bad_align;
      assign bad_mode  = (raw.mode == ELEM_RSVD);
      assign bad_dim   = (raw.dim_m == '0) || (raw.dim_n == '0);
      assign bad_align = (dst & ALIGN_MASK) != '0;

      always_comb begin
        if (!raw.en)        code = REJ_NONE;
        else if (bad_mode)  code = REJ_MODE;
        else if (bad_dim)   code = REJ_DIM;
        else if (bad_align) code = REJ_ALIGN;
        else                code = REJ_NONE;
        clean = raw.en ? raw : '0;
      end
    end else begin : g_absent
      always_comb begin
        code  = raw.en ? REJ_NO_HW : REJ_NONE;
        clean = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/xpose_slot.sv
module xpose_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         drain,
  output logic         valid,
  output logic         free,
  output logic [W-1:0] q
);

  assign free = !valid || drain;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (drain) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

endmodule

// File: rtl/xpose_req_decoder.sv
module xpose_req_decoder
  import xpose_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 32,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned BUS_BYTES = 8,
  parameter bit          XPOSE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_regform,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [31:0]       in_cfg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [LEN_W-1:0]  out_len,
  output logic [31:0]       out_cfg,
  output logic              out_xpose,
  output logic [1:0]        out_mode,
  output logic [11:0]       out_dim_m,
  output logic [11:0]       out_dim_n,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [2:0]        rsp_code
);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  len;
    logic [CFG_W-1:0]  cfg;
    xpose_opt_t        opt;
  } issue_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    rej_code_e       code;
  } reply_t;

  localparam int unsigned ISSUE_W = $bits(issue_t);
  localparam int unsigned REPLY_W = $bits(reply_t);

  xpose_opt_t raw_opt, clean_opt;
  rej_code_e  rej;
  logic       accept, iss_free, rsp_free;
  issue_t     iss_d, iss_q;
  reply_t     rep_d, rep_q;

  xpose_field_decode i_decode (
    .regform (in_regform),
    .cfg     (in_cfg),
    .raw     (raw_opt)
  );

  xpose_rule_check #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .XPOSE_EN  (XPOSE_EN)
  ) i_rules (
    .raw   (raw_opt),
    .dst   (in_dst),
    .code  (rej),
    .clean (clean_opt)
  );

  assign in_ready = iss_free && rsp_free;
  assign accept   = in_valid && in_ready;

  assign iss_d = '{id: in_id, src: in_src, dst: in_dst, len: in_len,
                   cfg: in_cfg, opt: clean_opt};
  assign rep_d = '{id: in_id, code: rej};

  xpose_slot #(.W(ISSUE_W)) i_issue_slot (
    .clk   (clk),
    .rst   (rst),
    .load  (accept && (rej == REJ_NONE)),
    .d     (iss_d),
    .drain (out_ready),
    .valid (out_valid),
    .free  (iss_free),
    .q     (iss_q)
  );

  xpose_slot #(.W(REPLY_W)) i_reply_slot (
    .clk   (clk),
    .rst   (rst),
    .load  (accept && (rej != REJ_NONE)),
    .d     (rep_d),
    .drain (rsp_ready),
    .valid (rsp_valid),
    .free  (rsp_free),
    .q     (rep_q)
  );

  assign out_id    = iss_q.id;
  assign out_src   = iss_q.src;
  assign out_dst   = iss_q.dst;
  assign out_len   = iss_q.len;
  assign out_cfg   = iss_q.cfg;
  assign out_xpose = iss_q.opt.en;
  assign out_mode  = iss_q.opt.mode;
  assign out_dim_m = iss_q.opt.dim_m;
  assign out_dim_n = iss_q.opt.dim_n;
  assign rsp_id    = rep_q.id;
  assign rsp_code  = rep_q.code;

endmodule

// File: rtl/xpose_req_decoder_chk.sv
module xpose_req_decoder_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned BUS_BYTES = 8,
  parameter bit          XPOSE_EN  = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ID_W-1:0]   out_id,
  input logic [ADDR_W-1:0] out_dst,
  input logic              out_xpose,
  input logic [1:0]        out_mode,
  input logic [11:0]       out_dim_m,
  input logic [11:0]       out_dim_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ID_W-1:0]   rsp_id,
  input logic [2:0]        rsp_code
);

  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(BUS_BYTES - 1);

  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_dst)
      && $stable(out_xpose) && $stable(out_mode) && $stable(out_dim_m) && $stable(out_dim_n));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_code));

  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) || (rsp_valid && !rsp_ready) |-> !in_ready);

  p_lands_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid || rsp_valid);

  p_zero_opts_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_xpose |-> out_mode == 2'b00 && out_dim_m == '0 && out_dim_n == '0);

  p_no_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_xpose |-> out_mode != 2'b11);

  p_dims_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_xpose |-> out_dim_m != '0 && out_dim_n != '0);

  p_align_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_xpose |-> (out_dst & MASK) == '0);

  p_code_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_code >= 3'd1 && rsp_code <= 3'd4);

  generate
    if (!XPOSE_EN) begin : g_off
      p_no_hw_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_xpose);
    end
  endgenerate

endmodule

bind xpose_req_decoder xpose_req_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .ID_W      (ID_W),
  .BUS_BYTES (BUS_BYTES),
  .XPOSE_EN  (XPOSE_EN)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_id    (out_id),
  .out_dst   (out_dst),
  .out_xpose (out_xpose),
  .out_mode  (out_mode),
  .out_dim_m (out_dim_m),
  .out_dim_n (out_dim_n),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_id    (rsp_id),
  .rsp_code  (rsp_code)
);

// File: tb/test_xpose_req_decoder.sv
`timescale 1ns/1ps
module test_xpose_req_decoder;

  localparam int AW = 32, LW = 32, IW = 4, BB = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 0, in_regform = 0, out_ready = 1, rsp_ready = 1;
  logic [IW-1:0] in_id = '0;
  logic [AW-1:0] in_src = '0, in_dst = '0;
  logic [LW-1:0] in_len = '0;
  logic [31:0]   in_cfg = '0;

  logic [1:0]    d_rdy, d_ov, d_rv, d_xp;
  logic [IW-1:0] d_oid [2];
  logic [IW-1:0] d_rid [2];
  logic [AW-1:0] d_src [2];
  logic [AW-1:0] d_dst [2];
  logic [LW-1:0] d_len [2];
  logic [31:0]   d_cfg [2];
  logic [1:0]    d_mode [2];
  logic [11:0]   d_m [2];
  logic [11:0]   d_n [2];
  logic [2:0]    d_code [2];

  xpose_req_decoder #(.ADDR_W(AW), .LEN_W(LW), .ID_W(IW), .BUS_BYTES(BB), .XPOSE_EN(1'b1))
  i_xpose_req_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(d_rdy[0]), .in_regform(in_regform),
    .in_id(in_id), .in_src(in_src), .in_dst(in_dst), .in_len(in_len), .in_cfg(in_cfg),
    .out_valid(d_ov[0]), .out_ready(out_ready), .out_id(d_oid[0]), .out_src(d_src[0]),
    .out_dst(d_dst[0]), .out_len(d_len[0]), .out_cfg(d_cfg[0]), .out_xpose(d_xp[0]),
    .out_mode(d_mode[0]), .out_dim_m(d_m[0]), .out_dim_n(d_n[0]),
    .rsp_valid(d_rv[0]), .rsp_ready(rsp_ready), .rsp_id(d_rid[0]), .rsp_code(d_code[0]));

  xpose_req_decoder #(.ADDR_W(AW), .LEN_W(LW), .ID_W(IW), .BUS_BYTES(BB), .XPOSE_EN(1'b0))
  i_xpose_req_decoder_off (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(d_rdy[1]), .in_regform(in_regform),
    .in_id(in_id), .in_src(in_src), .in_dst(in_dst), .in_len(in_len), .in_cfg(in_cfg),
    .out_valid(d_ov[1]), .out_ready(out_ready), .out_id(d_oid[1]), .out_src(d_src[1]),
    .out_dst(d_dst[1]), .out_len(d_len[1]), .out_cfg(d_cfg[1]), .out_xpose(d_xp[1]),
    .out_mode(d_mode[1]), .out_dim_m(d_m[1]), .out_dim_n(d_n[1]),
    .rsp_valid(d_rv[1]), .rsp_ready(rsp_ready), .rsp_id(d_rid[1]), .rsp_code(d_code[1]));

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference: rejection cause from the requirements (R5..R9, priority R8)
  function automatic logic [2:0] ref_code(bit en, bit regf, logic [31:0] cfg, logic [AW-1:0] dst);
    if (!regf || !cfg[5]) return 3'd0;
    if (!en) return 3'd1;
    if (cfg[7:6] == 2'b11) return 3'd2;
    if (cfg[19:8] == 0 || cfg[31:20] == 0) return 3'd3;
    if (dst % BB != 0) return 3'd4;
    return 3'd0;
  endfunction

  // Model state per DUT copy
  bit e_ov [2], e_rv [2];
  logic [IW-1:0] e_oid [2], e_rid [2];
  logic [AW-1:0] e_src [2], e_dst [2];
  logic [LW-1:0] e_len [2];
  logic [31:0] e_cfg [2];
  bit e_xp [2];
  logic [1:0] e_mode [2];
  logic [11:0] e_m [2], e_n [2];
  logic [2:0] e_code [2];
  string e_tag [2], e_rtag [2];

  function automatic bit exp_rdy(int k);
    return (!e_ov[k] || out_ready) && (!e_rv[k] || rsp_ready);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        e_ov[k] = 0; e_rv[k] = 0;
      end else begin
        bit acc;
        logic [2:0] c;
        acc = in_valid && exp_rdy(k);
        c = ref_code(k == 0, in_regform, in_cfg, in_dst);
        if (e_ov[k] && out_ready) e_ov[k] = 0;
        if (e_rv[k] && rsp_ready) e_rv[k] = 0;
        if (acc && c != 0) begin
          e_rv[k] = 1; e_rid[k] = in_id; e_code[k] = c;
          e_rtag[k] = (c == 1) ? "R9" : (c == 2) ? "R5" : (c == 3) ? "R6" : "R7";
        end else if (acc) begin
          bit x;
          x = (k == 0) && in_regform && in_cfg[5];
          e_ov[k] = 1; e_oid[k] = in_id; e_src[k] = in_src; e_dst[k] = in_dst;
          e_len[k] = in_len; e_cfg[k] = in_cfg; e_xp[k] = x;
          e_mode[k] = x ? in_cfg[7:6] : 2'b00;
          e_m[k] = x ? in_cfg[19:8] : 12'd0;
          e_n[k] = x ? in_cfg[31:20] : 12'd0;
          e_tag[k] = !in_regform ? "R4" : !in_cfg[5] ? "R3" : (k == 1) ? "R9" : "R2";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk(d_rdy[k] == exp_rdy(k), "R11", $sformatf("dut%0d in_ready", k), d_rdy[k], exp_rdy(k));
        chk(d_ov[k] == e_ov[k], "R12", $sformatf("dut%0d out_valid", k), d_ov[k], e_ov[k]);
        chk(d_rv[k] == e_rv[k], "R10", $sformatf("dut%0d rsp_valid", k), d_rv[k], e_rv[k]);
        if (e_ov[k] && d_ov[k]) begin
          chk({d_oid[k], d_src[k], d_dst[k], d_len[k], d_cfg[k]} ==
              {e_oid[k], e_src[k], e_dst[k], e_len[k], e_cfg[k]},
              e_tag[k], $sformatf("dut%0d payload dst", k), d_dst[k], e_dst[k]);
          chk({d_xp[k], d_mode[k], d_m[k], d_n[k]} == {e_xp[k], e_mode[k], e_m[k], e_n[k]},
              e_tag[k], $sformatf("dut%0d options", k),
              {d_xp[k], d_mode[k], d_m[k], d_n[k]}, {e_xp[k], e_mode[k], e_m[k], e_n[k]});
        end
        if (e_rv[k] && d_rv[k]) begin
          chk(d_code[k] == e_code[k], e_rtag[k], $sformatf("dut%0d rsp_code", k), d_code[k], e_code[k]);
          chk(d_rid[k] == e_rid[k], "R10", $sformatf("dut%0d rsp_id", k), d_rid[k], e_rid[k]);
        end
      end
    end
  end

  function automatic logic [31:0] mk(bit en, logic [1:0] mode, logic [11:0] m, logic [11:0] n,
                                     logic [4:0] low);
    return {n, m, mode, en, low};
  endfunction

  task automatic send(bit regf, logic [31:0] cfg, logic [AW-1:0] dst);
    @(posedge clk); #1;
    in_valid = 1; in_regform = regf; in_cfg = cfg; in_dst = dst;
    in_id = in_id + 1; in_src = in_src + 32'h40; in_len = in_len + 3;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: nothing pending right after reset
    chk(d_ov == 2'b00 && d_rv == 2'b00, "R1", "valids after reset", {d_ov, d_rv}, 0);
    send(1, mk(1, 2'b00, 12'd3, 12'd5, 5'h11), 32'h1000);      // R2 8-bit legal
    send(1, mk(1, 2'b01, 12'hFFF, 12'hFFF, 5'h00), 32'h2008);  // R2 16-bit max dims
    send(1, mk(1, 2'b10, 12'd1, 12'd1, 5'h1F), 32'h0);         // R2 32-bit
    send(1, mk(0, 2'b11, 12'd0, 12'd7, 5'h0A), 32'h3);         // R3 enable clear, junk fields
    send(0, mk(1, 2'b11, 12'd0, 12'd0, 5'h04), 32'h5);         // R4 not register form
    send(1, mk(1, 2'b11, 12'd4, 12'd4, 5'h00), 32'h40);        // R5 reserved mode
    send(1, mk(1, 2'b00, 12'd0, 12'd4, 5'h00), 32'h40);        // R6 M zero
    send(1, mk(1, 2'b01, 12'd4, 12'd0, 5'h00), 32'h40);        // R6 N zero
    send(1, mk(1, 2'b10, 12'd4, 12'd4, 5'h00), 32'h44);        // R7 misaligned
    send(1, mk(1, 2'b11, 12'd0, 12'd4, 5'h00), 32'h43);        // R8 mode beats dim, align
    send(1, mk(1, 2'b00, 12'd9, 12'd0, 5'h00), 32'h41);        // R8 dim beats align
    send(1, mk(1, 2'b00, 12'd2, 12'd2, 5'h00), 32'h80);        // R10 clean after reject
    // R11 back-pressure: held request stream with blocked readies
    @(posedge clk); #1;
    out_ready = 0; rsp_ready = 0;
    in_valid = 1; in_regform = 1; in_cfg = mk(1, 2'b00, 12'd6, 12'd6, 5'h0); in_dst = 32'h100;
    repeat (3) @(posedge clk);
    #1 in_cfg = mk(1, 2'b11, 12'd6, 12'd6, 5'h0); in_id = in_id + 1;
    repeat (2) @(posedge clk);
    #1 out_ready = 1;
    repeat (2) @(posedge clk);
    #1 rsp_ready = 1;
    repeat (2) @(posedge clk);
    #1 in_valid = 0;
    // Mixed phase: pseudo-random requests and readies (R12 R11 R10)
    begin
      logic [31:0] lf;
      lf = 32'hACE1_2357;
      for (int i = 0; i < 400; i++) begin
        @(posedge clk); #1;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        in_valid = lf[0] | lf[9];
        in_regform = lf[3] | lf[12];
        in_cfg = {lf[7] ? 12'd0 : lf[31:20], lf[19:8], lf[17:16], lf[5] | lf[14], lf[4:0]};
        in_dst = {lf[30:4], (lf[2] & lf[11]) ? lf[6:4] : 3'b000, 2'b00} ^ 32'h0;
        in_id = lf[27:24];
        in_src = lf ^ 32'h5555_0000;
        in_len = {16'h0, lf[15:0]};
        out_ready = lf[13] | lf[25];
        rsp_ready = lf[18] | lf[29];
      end
      @(posedge clk); #1;
      in_valid = 0; out_ready = 1; rsp_ready = 1;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule